// File: doc/BRIEF.md
# Interleaved Memory Block Fill Controller

This block serves one cache-line fill. A requester pulses a start input with a block address; the controller then models, cycle for cycle, a narrow clocked bus to a main memory. The bus carries the address in one cycle. Each array access lasts a fixed number of bus cycles, and each transfer back to the requester takes one bus cycle. The four words of the block come back on a bus of four lanes. Lane i carries word offset i, and a lane mask marks which words a transfer holds. One cycle after the last transfer, a one-cycle done pulse marks the end of the fill. The total fill length in bus cycles is held on an output.

A build parameter selects the memory organization, and with it the fill schedule. In the narrow organization a single one-word memory performs four accesses in turn, each followed by its own transfer. In the wide organization one access fetches all four words, and they return in a single transfer. In the banked organization four banks access at the same time and then return one word per cycle. The storage is four banks, and word i of a block sits in bank i. The banks hold fixed contents derived from the word address, so a fill can be checked without a load path.

Top module: `mem_fill_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it is released, busy_o, done_o and rd_valid_o are 0, rd_mask_o and rd_data_o are all zero, and fill_cycles_o is zero.
- R2: The word at word address w = 4*blk_i + i holds w in its lower 16 bits and the bitwise inverse of those 16 bits in its upper 16 bits. Word i always appears in lane i of rd_data_o (bits 32*i+31 down to 32*i), and every lane outside rd_mask_o is zero.
- R3: Fill cycle 1 is the cycle after the clock edge that accepts start_i. In the narrow organization (ORG = 0), word i is delivered alone in fill cycle 17 + 16*i, with rd_valid_o high and rd_mask_o equal to 1 << i, giving the offsets 0 to 3 in ascending order.
- R4: In the wide organization (ORG = 1), all four words are delivered together in fill cycle 17, with rd_mask_o equal to 4'b1111, and in no other cycle.
- R5: In the banked organization (ORG = 2), word i is delivered alone in fill cycle 17 + i, with rd_mask_o equal to 1 << i.
- R6: done_o is high for exactly one cycle, fill cycle N + 1, where N is 65, 17 or 20 for the narrow, wide and banked organizations. From that cycle until the next accepted start, fill_cycles_o equals N.
- R7: busy_o is high in fill cycles 1 through N + 1 and low in every other cycle. A start_i pulse seen while busy_o is low is always accepted.
- R8: A start_i pulse that arrives while busy_o is high, including in the done cycle, has no effect: no extra transfer, done or busy period follows, and the words returned come from the block address that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle fill request |
| blk_i | input | BLK_W | Block address, sampled with an accepted start |
| busy_o | output | 1 | Fill in progress, up to and including the done cycle |
| done_o | output | 1 | One-cycle end-of-fill pulse |
| rd_valid_o | output | 1 | A transfer is on the bus this cycle |
| rd_mask_o | output | WORDS | Word offsets carried by this transfer |
| rd_data_o | output | WORDS*DATA_W | Lane i holds word offset i |
| fill_cycles_o | output | FILL_W | Bus cycles of the last completed fill |

## Verification
The assertions assume that start_i is a single-cycle pulse and that the block address is steady on the edge that samples it. Under those conditions, busy may fall only after a done pulse, and a start seen while idle must raise busy. The stimulus therefore raises start_i for one cycle at a time and changes blk_i only together with it. The stimulus sends extra pulses only at fixed points inside a fill, one of them in the done cycle of the shortest schedule, so every other pulse lands while all three organizations are idle.

// File: rtl/mfc_pkg.sv
package mfc_pkg;

  typedef enum logic [1:0] {
    ORG_NARROW = 2'd0,
    ORG_WIDE   = 2'd1,
    ORG_BANKED = 2'd2
  } org_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_ACC,
    PH_XFER,
    PH_DONE
  } phase_e;

endpackage

// File: rtl/mfc_bank.sv
// One storage bank with a registered read port, suitable for block RAM.
module mfc_bank #(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 64,
  parameter int BANKS   = 4,
  parameter int BANK_ID = 0,
  localparam int AW     = $clog2(DEPTH),
  localparam int HALF   = DATA_W / 2
) (
  input  logic              clk,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Fixed contents: lower half is the word address, upper half its inverse.
  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      int unsigned w;
      w = a * BANKS + BANK_ID;
      mem[a] = {~HALF'(w), HALF'(w)};
    end
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/mfc_seq.sv
// Bus schedule: address phase, array access, transfers, done.
module mfc_seq #(
  parameter mfc_pkg::org_e ORG = mfc_pkg::ORG_BANKED,
  parameter int WORDS    = 4,
  parameter int ADDR_CYC = 1,
  parameter int ACC_CYC  = 15,
  parameter int FILL_W   = 8,
  localparam int WIDX_W  = $clog2(WORDS),
  localparam int CNT_W   = $clog2(ADDR_CYC + ACC_CYC + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  output logic                 accept_o,
  output mfc_pkg::phase_e      ph_d_o,
  output logic [WIDX_W-1:0]    word_d_o,
  output logic [FILL_W-1:0]    fill_q_o
);
  import mfc_pkg::*;

  phase_e            ph_q, ph_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WIDX_W-1:0] word_q, word_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              accept;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    word_d = word_q;
    accept = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          accept = 1'b1;
          ph_d   = PH_ADDR;
          cnt_d  = CNT_W'(ADDR_CYC - 1);
          word_d = '0;
        end
      end
      PH_ADDR: begin
        if (cnt_q == '0) begin
          ph_d  = PH_ACC;
          cnt_d = CNT_W'(ACC_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACC: begin
        if (cnt_q == '0) ph_d = PH_XFER;
        else             cnt_d = cnt_q - 1'b1;
      end
      PH_XFER: begin
        if (ORG == ORG_WIDE || word_q == WIDX_W'(WORDS - 1)) begin
          ph_d = PH_DONE;
        end else begin
          word_d = word_q + 1'b1;
          if (ORG == ORG_NARROW) begin
            ph_d  = PH_ACC;
            cnt_d = CNT_W'(ACC_CYC - 1);
          end
        end
      end
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  // Counts the index of the current fill cycle.
  always_comb begin
    fill_d = fill_q;
    if (accept) begin
      fill_d = FILL_W'(1);
    end else if (ph_d == PH_ADDR || ph_d == PH_ACC || ph_d == PH_XFER) begin
      fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      word_q <= '0;
      fill_q <= '0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      word_q <= word_d;
      fill_q <= fill_d;
    end
  end

  assign accept_o = accept;
  assign ph_d_o   = ph_d;
  assign word_d_o = word_d;
  assign fill_q_o = fill_q;

endmodule

// File: rtl/mem_fill_ctrl.sv
module mem_fill_ctrl #(
  parameter mfc_pkg::org_e ORG = mfc_pkg::ORG_BANKED,
  parameter int DATA_W   = 32,
  parameter int WORDS    = 4,
  parameter int BLK_W    = 6,
  parameter int ADDR_CYC = 1,
  parameter int ACC_CYC  = 15,
  parameter int FILL_W   = 8,
  localparam int BUS_W   = WORDS * DATA_W,
  localparam int DEPTH   = 2 ** BLK_W,
  localparam int WIDX_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [BLK_W-1:0]  blk_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_valid_o,
  output logic [WORDS-1:0]  rd_mask_o,
  output logic [BUS_W-1:0]  rd_data_o,
  output logic [FILL_W-1:0] fill_cycles_o
);
  import mfc_pkg::*;

  logic              accept;
  phase_e            ph_d;
  logic [WIDX_W-1:0] word_d;
  logic [FILL_W-1:0] fill_q;
  logic [BLK_W-1:0]  blk_q;
  logic [DATA_W-1:0] bank_dout [WORDS];
  logic [WORDS-1:0]  lane_hit;
  logic [BUS_W-1:0]  bus_d;

  mfc_seq #(
    .ORG(ORG), .WORDS(WORDS), .ADDR_CYC(ADDR_CYC),
    .ACC_CYC(ACC_CYC), .FILL_W(FILL_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .accept_o(accept),
    .ph_d_o(ph_d), .word_d_o(word_d), .fill_q_o(fill_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         blk_q <= '0;
    else if (accept) blk_q <= blk_i;
  end

  // Word i of every block lives in bank i.
  for (genvar b = 0; b < WORDS; b++) begin : g_bank
    mfc_bank #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .BANKS(WORDS), .BANK_ID(b)
    ) u_bank (
      .clk(clk), .rd_addr(blk_q), .rd_data(bank_dout[b])
    );
  end

  always_comb begin
    for (int b = 0; b < WORDS; b++) begin
      lane_hit[b] = (ph_d == PH_XFER) &&
                    ((ORG == ORG_WIDE) || (word_d == WIDX_W'(b)));
      bus_d[b*DATA_W +: DATA_W] = lane_hit[b] ? bank_dout[b] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o        <= 1'b0;
      done_o        <= 1'b0;
      rd_valid_o    <= 1'b0;
      rd_mask_o     <= '0;
      rd_data_o     <= '0;
      fill_cycles_o <= '0;
    end else begin
      busy_o     <= (ph_d != PH_IDLE);
      done_o     <= (ph_d == PH_DONE);
      rd_valid_o <= (ph_d == PH_XFER);
      rd_mask_o  <= lane_hit;
      rd_data_o  <= bus_d;
      if (ph_d == PH_DONE) fill_cycles_o <= fill_q;
    end
  end

endmodule

// File: rtl/mem_fill_ctrl_chk.sv
module mem_fill_ctrl_chk #(
  parameter mfc_pkg::org_e ORG = mfc_pkg::ORG_BANKED,
  parameter int WORDS  = 4,
  parameter int BUS_W  = 128,
  parameter int FILL_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              rd_valid_o,
  input logic [WORDS-1:0]  rd_mask_o,
  input logic [BUS_W-1:0]  rd_data_o,
  input logic [FILL_W-1:0] fill_cycles_o
);

  p_idle_bus_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_valid_o |-> (rd_mask_o == '0 && rd_data_o == '0));

  p_mask_shape_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> ((ORG == mfc_pkg::ORG_WIDE) ? (rd_mask_o == '1)
                                               : ($countones(rd_mask_o) == 1)));

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_fill_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(fill_cycles_o));

  p_done_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_o);

  p_xfer_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> (busy_o && !done_o));

  p_accept_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i) |=> busy_o);

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !done_o) |=> busy_o);

  p_done_no_restart_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !busy_o);

endmodule

bind mem_fill_ctrl mem_fill_ctrl_chk #(
  .ORG(ORG), .WORDS(WORDS), .BUS_W(WORDS * DATA_W), .FILL_W(FILL_W)
) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .rd_valid_o(rd_valid_o), .rd_mask_o(rd_mask_o),
  .rd_data_o(rd_data_o), .fill_cycles_o(fill_cycles_o)
);

// File: tb/mem_fill_ctrl_bench.sv
module mem_fill_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 3;

  typedef struct {
    bit          is_done;
    int          cyc;
    logic [3:0]  mask;
    logic [127:0] data;
    int          fill;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [5:0] blk = '0;

  logic         busy [NM];
  logic         done [NM];
  logic         vld  [NM];
  logic [3:0]   mask [NM];
  logic [127:0] data [NM];
  logic [7:0]   fill [NM];

  int checks = 0;
  int errors = 0;
  int tb_cyc = 0;
  bit running = 1'b0;
  bit finished = 1'b0;
  int win_lo [NM];
  int win_hi [NM];
  item_t sbq [NM][$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tb_cyc <= tb_cyc + 1;

  for (genvar g = 0; g < NM; g++) begin : g_dut
    mem_fill_ctrl #(.ORG(mfc_pkg::org_e'(g))) u_mem_fill_ctrl (
      .clk(clk), .rst(rst), .start_i(start), .blk_i(blk),
      .busy_o(busy[g]), .done_o(done[g]), .rd_valid_o(vld[g]),
      .rd_mask_o(mask[g]), .rd_data_o(data[g]), .fill_cycles_o(fill[g])
    );
  end

  function automatic int fill_len(int m);
    return (m == 0) ? 65 : (m == 1) ? 17 : 20;
  endfunction

  function automatic int xfer_cyc(int m, int i);
    return (m == 0) ? 17 + 16 * i : (m == 1) ? 17 : 17 + i;
  endfunction

  function automatic logic [31:0] word_val(int b, int i);
    logic [15:0] w;
    w = 16'(b * 4 + i);
    return {~w, w};
  endfunction

  function automatic string req_of(int m);
    return (m == 0) ? "R3" : (m == 1) ? "R4" : "R5";
  endfunction

  task automatic chk(bit ok, string req, string what, int m,
                     logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s org%0d %s: actual %h expected %h", req, m, what, act, exp);
    end
  endtask

  // Driver: issue one fill and push the expected stream for every organization.
  task automatic do_fill(int b, bit poke);
    int c;
    @(negedge clk);
    c = tb_cyc;
    start = 1'b1;
    blk = 6'(b);
    for (int m = 0; m < NM; m++) begin
      item_t it;
      win_lo[m] = c + 1;
      win_hi[m] = c + fill_len(m) + 1;
      if (m == 1) begin
        it.is_done = 0; it.cyc = c + 17; it.mask = 4'hf; it.fill = 0;
        for (int i = 0; i < 4; i++) it.data[i*32 +: 32] = word_val(b, i);
        sbq[m].push_back(it);
      end else begin
        for (int i = 0; i < 4; i++) begin
          it.is_done = 0; it.cyc = c + xfer_cyc(m, i);
          it.mask = 4'(1 << i); it.data = '0; it.fill = 0;
          it.data[i*32 +: 32] = word_val(b, i);
          sbq[m].push_back(it);
        end
      end
      it.is_done = 1; it.cyc = c + fill_len(m) + 1;
      it.mask = '0; it.data = '0; it.fill = fill_len(m);
      sbq[m].push_back(it);
    end
    @(negedge clk);
    start = 1'b0;
    blk = '0;
    if (poke) begin
      // R8: pulses inside a fill, one in the done cycle of the wide schedule
      while (tb_cyc != c + 10) @(negedge clk);
      start = 1'b1; blk = 6'(b ^ 6'h3f);
      @(negedge clk);
      start = 1'b0; blk = '0;
      while (tb_cyc != c + 18) @(negedge clk);
      start = 1'b1; blk = 6'(b ^ 6'h15);
      @(negedge clk);
      start = 1'b0; blk = '0;
    end
    while (tb_cyc < c + 70) @(negedge clk);
    for (int m = 0; m < NM; m++) begin
      chk(sbq[m].size() == 0, "R8", "stream complete", m, 128'(sbq[m].size()), 0);
      chk(fill[m] == 8'(fill_len(m)), "R6", "fill count held", m,
          128'(fill[m]), 128'(fill_len(m)));
    end
  endtask

  // Monitor: compare outputs with the scoreboard away from the active edge.
  always @(negedge clk) begin
    if (running && !rst) begin
      for (int m = 0; m < NM; m++) begin
        bit exp_b;
        exp_b = (tb_cyc >= win_lo[m]) && (tb_cyc <= win_hi[m]);
        chk(busy[m] == exp_b, "R7", "busy", m, 128'(busy[m]), 128'(exp_b));
        if (vld[m] || done[m]) begin
          if (sbq[m].size() == 0) begin
            chk(0, "R8", "unexpected output", m, 128'(tb_cyc), 0);
          end else begin
            item_t it;
            it = sbq[m].pop_front();
            chk(done[m] == it.is_done, "R6", "done", m, 128'(done[m]), 128'(it.is_done));
            chk(tb_cyc == it.cyc, it.is_done ? "R6" : req_of(m), "cycle", m,
                128'(tb_cyc), 128'(it.cyc));
            if (it.is_done) begin
              chk(fill[m] == 8'(it.fill), "R6", "fill cycles", m,
                  128'(fill[m]), 128'(it.fill));
            end else begin
              chk(mask[m] == it.mask, req_of(m), "mask", m, 128'(mask[m]), 128'(it.mask));
              chk(data[m] == it.data, "R2", "data", m, data[m], it.data);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < NM; m++) begin win_lo[m] = -1; win_hi[m] = -2; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    for (int m = 0; m < NM; m++) begin
      chk(!busy[m] && !done[m] && !vld[m], "R1", "flags in reset", m,
          128'({busy[m], done[m], vld[m]}), 0);
    end
    rst = 1'b0;
    @(negedge clk);
    for (int m = 0; m < NM; m++) begin
      chk(!busy[m] && !done[m] && !vld[m], "R1", "flags after reset", m,
          128'({busy[m], done[m], vld[m]}), 0);
      chk(mask[m] == 0 && data[m] == 0, "R1", "bus after reset", m, data[m], 0);
      chk(fill[m] == 0, "R1", "fill after reset", m, 128'(fill[m]), 0);
    end
    running = 1'b1;
    do_fill(0, 0);
    do_fill(63, 0);
    do_fill(21, 1);
    do_fill(42, 0);
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule